// File: doc/BRIEF.md
# SDRAM Bank Burst Data Path

This block models the data side of one bank of a synchronous DRAM for a single open row. A command decoder upstream hands it decoded read, write, burst-stop and precharge strobes. An external burst counter supplies the column to use on every clock. The block counts out the programmed burst, writes byte-masked data into a behavioural row store, and returns read data with a per-byte-lane output enable. The read data comes out after a CAS latency of two or three clocks. An output enable that is low stands for a high-impedance data bus.

The mode fields (CAS latency select, burst length code, single-word write mode) arrive as plain inputs from the mode register that owns them. A new column, and a new command, may be presented on any clock. A new command cuts short whatever burst is running. A write also discards read words that are still waiting in the latency pipeline, so the bus is free on the write edge.

Top module: `sdr_burst_dp`

## Requirements
- R1: While reset is held, and in the cycle after it is released, both lane enables are low and the read data is zero.
- R2: With `cl3_i`=0 (latency 2) or 1 (latency 3), beat i of a read accepted at edge T is driven on `rdata_o` so that it is valid when sampled at edge T+i+latency.
- R3: `bl_code_i` encodes the burst length: 0=1, 1=2, 2=4, 3=8 and 7=continuous until stopped or interrupted. Other codes act as 1. Reads and writes both follow this length.
- R4: A write stores `wdata_i` into the column on `col_i` at the same edge as the write command, and stores one more word at each following edge of the burst.
- R5: Write mask latency is 0. `dqm_i[0]` high at an edge blocks DQ[7:0] and `dqm_i[1]` high blocks DQ[15:8] for the word written at that edge. The masked byte keeps its old value.
- R6: Read mask latency is 2. `dqm_i[b]` high at edge E drives `rd_oe_o[b]` low, and that lane of `rdata_o` to zero, for the data sampled at edge E+2.
- R7: After the last beat of a read burst the enables return low, unless a new read was issued on the clock after the last beat. In that case the words follow with no idle cycle.
- R8: A new read or write ends the running burst on its own edge. A stop or precharge strobe ends it with no further beat, while words already fetched are still delivered.
- R9: A write command discards every read word still in the latency pipeline. The enables are low for each sample that would have carried one.
- R10: With `single_wr_i`=1 a write stores exactly one word, whatever the burst length code.
- R11: The column is taken from `col_i` on every beat, so non-sequential column patterns are read back in the order presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd_i | input | 1 | Read command strobe |
| cmd_wr_i | input | 1 | Write command strobe (wins over read) |
| cmd_stop_i | input | 1 | Burst stop strobe |
| cmd_pre_i | input | 1 | Precharge strobe for this bank |
| col_i | input | 8 | Column for this beat, from the external burst counter |
| dqm_i | input | 2 | Byte mask, bit 0 for DQ[7:0], bit 1 for DQ[15:8] |
| cl3_i | input | 1 | CAS latency select, 0 = 2 clocks, 1 = 3 clocks |
| bl_code_i | input | 3 | Burst length code |
| single_wr_i | input | 1 | Single-word write mode |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero in a lane that is not enabled |
| rd_oe_o | output | 2 | Per-lane output enable, low means high impedance |

## Verification
On every cycle the assertions check several local rules. The enables are low after reset, and after any write command. A lane never drives when its mask was high two edges earlier. A stop or precharge yields no beat on the following edge, unless a new command arrives. Length-one reads and single-word writes end after their first beat. The bench scenarios are needed for the rest: the actual data values at both latencies, the byte-merge on masked writes, gapless back-to-back reads, and delivery of already fetched words after a stop. Those depend on data contents and on multi-cycle order, which the local rules do not capture.

// File: rtl/sdr_dp_pkg.sv
// Shared types and decode helpers for the SDRAM bank burst data path.
// Assumes the mode fields are already registered by their owner.
package sdr_dp_pkg;

    // Burst engine direction.
    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bst_mode_e;

    // Burst length code that means "run until stopped".
    localparam logic [2:0] BL_CODE_OPEN = 3'd7;

    // Number of beats for a finite burst length code; reserved codes give 1.
    function automatic int unsigned burst_beats(input logic [2:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdr_burst_ctl.sv
// Burst engine: decides, for each clock, whether a read beat or a write beat
// happens. Priority on one edge: write, then read, then stop/precharge.
// Assumes the column for each beat is supplied externally.
module sdr_burst_ctl
    import sdr_dp_pkg::*;
#(
    parameter int MAX_BL = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_rd_i,
    input  logic       cmd_wr_i,
    input  logic       cmd_stop_i,
    input  logic       cmd_pre_i,
    input  logic [2:0] bl_code_i,
    input  logic       single_wr_i,
    output logic       rd_beat_o,
    output logic       wr_beat_o
);

    localparam int CNT_W = $clog2(MAX_BL + 1);

    bst_mode_e        mode_q;
    logic [CNT_W-1:0] left_q;
    logic             open_q;
    logic [CNT_W-1:0] rd_len;
    logic [CNT_W-1:0] wr_len;
    logic             wr_open;
    logic             halt;
    logic             carry_on;

    // Decode the lengths a new command would start with.
    always_comb begin
        rd_len   = CNT_W'(burst_beats(bl_code_i));
        wr_open  = (bl_code_i == BL_CODE_OPEN) && !single_wr_i;
        wr_len   = single_wr_i ? CNT_W'(1) : rd_len;
        halt     = cmd_stop_i || cmd_pre_i;
        carry_on = (mode_q != BST_IDLE) && !cmd_rd_i && !cmd_wr_i && !halt;
    end

    // Beat strobes for this edge: new command or continuing burst.
    always_comb begin
        wr_beat_o = cmd_wr_i || (carry_on && mode_q == BST_WRITE);
        rd_beat_o = (cmd_rd_i && !cmd_wr_i) || (carry_on && mode_q == BST_READ);
    end

    // Burst state: start, count down, or end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BST_IDLE;
            left_q <= '0;
            open_q <= 1'b0;
        end else if (cmd_wr_i) begin
            open_q <= wr_open;
            left_q <= wr_len - CNT_W'(1);
            mode_q <= (wr_open || wr_len > CNT_W'(1)) ? BST_WRITE : BST_IDLE;
        end else if (cmd_rd_i) begin
            open_q <= (bl_code_i == BL_CODE_OPEN);
            left_q <= rd_len - CNT_W'(1);
            mode_q <= ((bl_code_i == BL_CODE_OPEN) || rd_len > CNT_W'(1)) ? BST_READ : BST_IDLE;
        end else if (halt) begin
            mode_q <= BST_IDLE;
            open_q <= 1'b0;
        end else if (carry_on && !open_q) begin
            left_q <= left_q - CNT_W'(1);
            if (left_q <= CNT_W'(1)) begin
                mode_q <= BST_IDLE;
            end
        end
    end

    // A stop or precharge alone leaves no beat on the next edge.
    assert_halt_ends_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cmd_rd_i && !cmd_wr_i) |=>
            (!(rd_beat_o || wr_beat_o) || cmd_rd_i || cmd_wr_i));

    // A single-word write has no second beat.
    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && single_wr_i) |=> (!wr_beat_o || cmd_wr_i));

    // A length-one read has no second beat.
    assert_len_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd_i && !cmd_wr_i && bl_code_i == 3'd0) |=> (!rd_beat_o || cmd_rd_i));

endmodule

// File: rtl/sdr_row_store.sv
// Behavioural storage for one open row, with a byte-lane write enable.
// Combinational read; contents are not reset (as in a real array).
module sdr_row_store #(
    parameter int DQ_W  = 16,
    parameter int COL_W = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [LANES-1:0] be_i,
    input  logic [COL_W-1:0] addr_i,
    input  logic [DQ_W-1:0]  wdata_i,
    output logic [DQ_W-1:0]  rdata_o
);

    localparam int WORDS  = 1 << COL_W;
    localparam int LANE_W = DQ_W / LANES;

    logic [DQ_W-1:0] mem_q [WORDS];

    // Store the enabled byte lanes of a write beat.
    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int b = 0; b < LANES; b++) begin
                if (be_i[b]) begin
                    mem_q[addr_i][b*LANE_W +: LANE_W] <= wdata_i[b*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Fetch the word at the current column.
    always_comb rdata_o = mem_q[addr_i];

endmodule

// File: rtl/sdr_rd_pipe.sv
// Read latency and read mask pipeline. Words pushed at edge T are shown
// after edge T+1 (latency 2) or T+2 (latency 3). The mask taken at edge E
// gates the lanes shown after edge E+1. A flush discards every pending word.
module sdr_rd_pipe #(
    parameter int DQ_W  = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             flush_i,
    input  logic [DQ_W-1:0]  din_i,
    input  logic [LANES-1:0] dqm_i,
    input  logic             cl3_i,
    output logic [DQ_W-1:0]  dout_o,
    output logic [LANES-1:0] oe_o
);

    localparam int STAGES = 3;              // covers the longest latency
    localparam int LANE_W = DQ_W / LANES;

    logic [DQ_W-1:0]  dat_q [STAGES];
    logic [STAGES-1:0] vld_q;
    logic [LANES-1:0] msk1_q;
    logic [LANES-1:0] msk2_q;
    logic [DQ_W-1:0]  sel_d;
    logic             sel_v;

    // Shift data and valid flags; a flush clears all valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < STAGES; s++) dat_q[s] <= '0;
        end else begin
            vld_q <= flush_i ? '0 : {vld_q[STAGES-2:0], push_i};
            dat_q[0] <= din_i;
            for (int s = 1; s < STAGES; s++) dat_q[s] <= dat_q[s-1];
        end
    end

    // Two-stage mask delay for the read mask latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk1_q <= '1;
            msk2_q <= '1;
        end else begin
            msk1_q <= dqm_i;
            msk2_q <= msk1_q;
        end
    end

    // Pick the stage that matches the programmed latency.
    always_comb begin
        sel_v = cl3_i ? vld_q[2] : vld_q[1];
        sel_d = cl3_i ? dat_q[2] : dat_q[1];
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign oe_o[b] = sel_v & ~msk2_q[b];
        assign dout_o[b*LANE_W +: LANE_W] = oe_o[b] ? sel_d[b*LANE_W +: LANE_W] : '0;
    end

    // After a write command no pending read word reaches the bus.
    assert_write_cancels_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (oe_o == '0));

    // A lane masked two edges ago never drives.
    assert_read_mask_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> ((oe_o & $past(dqm_i, 2)) == '0));

endmodule

// File: rtl/sdr_burst_dp.sv
// Top of the bank burst data path: burst engine, row store and read pipe.
// Assumes decoded command strobes and a column from an external counter.
module sdr_burst_dp #(
    parameter int DQ_W   = 16,
    parameter int COL_W  = 8,
    parameter int MAX_BL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd_i,
    input  logic              cmd_wr_i,
    input  logic              cmd_stop_i,
    input  logic              cmd_pre_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DQ_W/8-1:0] dqm_i,
    input  logic              cl3_i,
    input  logic [2:0]        bl_code_i,
    input  logic              single_wr_i,
    input  logic [DQ_W-1:0]   wdata_i,
    output logic [DQ_W-1:0]   rdata_o,
    output logic [DQ_W/8-1:0] rd_oe_o
);

    localparam int LANES = DQ_W / 8;

    logic            rd_beat;
    logic            wr_beat;
    logic [DQ_W-1:0] fetch;

    sdr_burst_ctl #(.MAX_BL(MAX_BL)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_rd_i   (cmd_rd_i),
        .cmd_wr_i   (cmd_wr_i),
        .cmd_stop_i (cmd_stop_i),
        .cmd_pre_i  (cmd_pre_i),
        .bl_code_i  (bl_code_i),
        .single_wr_i(single_wr_i),
        .rd_beat_o  (rd_beat),
        .wr_beat_o  (wr_beat)
    );

    sdr_row_store #(.DQ_W(DQ_W), .COL_W(COL_W), .LANES(LANES)) u_row (
        .clk    (clk),
        .we_i   (wr_beat),
        .be_i   (~dqm_i),
        .addr_i (col_i),
        .wdata_i(wdata_i),
        .rdata_o(fetch)
    );

    sdr_rd_pipe #(.DQ_W(DQ_W), .LANES(LANES)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (rd_beat),
        .flush_i(cmd_wr_i),
        .din_i  (fetch),
        .dqm_i  (dqm_i),
        .cl3_i  (cl3_i),
        .dout_o (rdata_o),
        .oe_o   (rd_oe_o)
    );

    // Reset leaves the bus released on the following cycle.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_oe_o == '0));

endmodule

// File: tb/sim_sdr_burst_dp.sv
`timescale 1ns/1ps
module sim_sdr_burst_dp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_rd = 0, cmd_wr = 0, cmd_stop = 0, cmd_pre = 0;
    logic [7:0]  col = '0;
    logic [1:0]  dqm = '0;
    logic        cl3 = 1'b0;
    logic [2:0]  bl_code = '0;
    logic        single_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  rd_oe;

    sdr_burst_dp u0 (
        .clk(clk), .rst_n(rst_n), .cmd_rd_i(cmd_rd), .cmd_wr_i(cmd_wr),
        .cmd_stop_i(cmd_stop), .cmd_pre_i(cmd_pre), .col_i(col), .dqm_i(dqm),
        .cl3_i(cl3), .bl_code_i(bl_code), .single_wr_i(single_wr),
        .wdata_i(wdata), .rdata_o(rdata), .rd_oe_o(rd_oe)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int          cyc;
        logic [1:0]  oe;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int          cl = 2;
    logic [15:0] shadow [32];

    always @(posedge clk) cyc = cyc + 1;

    // Monitor: compare due scoreboard items against the outputs.
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (e.cyc != cyc || rd_oe !== e.oe || rdata !== e.data) begin
                errors++;
                $display("FAIL %s cycle %0d: oe=%b data=%h, expected oe=%b data=%h (due %0d)",
                         e.tag, cyc, rd_oe, rdata, e.oe, e.data, e.cyc);
            end
        end
    end

    task automatic push_exp(int c, logic [1:0] oe, logic [15:0] d, string tag);
        exp_t e;
        e.cyc = c; e.oe = oe; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(logic rd, logic wr, logic st, logic pr, int c, logic [1:0] m, logic [15:0] wd);
        cmd_rd = rd; cmd_wr = wr; cmd_stop = st; cmd_pre = pr;
        col = 8'(c); dqm = m; wdata = wd;
        cl3 = (cl == 3);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 2'b00, 16'h0);
    endtask

    // Read burst driver: pushes expected beats (with read mask) and quiet samples.
    task automatic rd_seq(int start, int step, int ncyc, int neff, bit quiet,
                          int mbeat, logic [1:0] mval, string tag);
        int k = cyc;
        for (int i = 0; i < ncyc; i++) begin
            int c = (start + i * step) % 32;
            if (i < neff) begin
                logic [1:0] mk = (mbeat >= 0 && mbeat + 2 == i + cl) ? mval : 2'b00;
                logic [1:0] oe = ~mk;
                push_exp(k + i + cl, oe,
                         {oe[1] ? shadow[c][15:8] : 8'h00, oe[0] ? shadow[c][7:0] : 8'h00}, tag);
            end
            drive(i == 0, 0, 0, 0, c, (i == mbeat) ? mval : 2'b00, 16'h0);
        end
        if (quiet) begin
            for (int j = neff; j <= ncyc; j++) push_exp(k + j + cl, 2'b00, 16'h0, tag);
        end
    endtask

    // Write burst driver: updates the bench's own copy of the row.
    task automatic wr_seq(int start, int ncyc, int neff, int mbeat, logic [1:0] mval,
                          logic [15:0] seed, bit quiet, string tag);
        int k = cyc;
        for (int i = 0; i < ncyc; i++) begin
            int c = (start + i) % 32;
            logic [15:0] wd = 16'(seed + i * 16'h0123);
            logic [1:0]  m  = (i == mbeat) ? mval : 2'b00;
            if (i < neff) begin
                if (!m[0]) shadow[c][7:0]  = wd[7:0];
                if (!m[1]) shadow[c][15:8] = wd[15:8];
            end
            if (quiet) push_exp(k + i + 1, 2'b00, 16'h0, tag);
            drive(0, i == 0, 0, 0, c, m, wd);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        checks++;   // R1: reset state
        if (rd_oe !== 2'b00 || rdata !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset: oe=%b data=%h, expected oe=00 data=0000", rd_oe, rdata);
        end
        rst_n = 1'b1;
        push_exp(cyc + 1, 2'b00, 16'h0, "R1");
        idle(2);

        // Fill columns 0..31 with a continuous write, then stop it (R3, R4).
        bl_code = 3'd7; cl = 2;
        wr_seq(0, 32, 32, -1, 2'b00, 16'h1000, 1, "R4");
        drive(0, 0, 1, 0, 0, 2'b00, 16'h0);
        idle(2);

        // Latency 2, length 4 (R2).
        bl_code = 3'd2;
        rd_seq(0, 1, 4, 4, 1, -1, 2'b00, "R2");
        idle(4);
        // Latency 3, length 2 (R2).
        cl = 3; bl_code = 3'd1;
        rd_seq(5, 3, 2, 2, 1, -1, 2'b00, "R2");
        idle(4);
        // Length 1 ignores further clocks (R3).
        bl_code = 3'd0;
        rd_seq(7, 1, 3, 1, 1, -1, 2'b00, "R3");
        idle(4);
        // Non-sequential columns every clock (R11).
        cl = 2; bl_code = 3'd3;
        rd_seq(3, 5, 8, 8, 1, -1, 2'b00, "R11");
        idle(4);

        // Write masks at latency 0 on each lane (R5).
        bl_code = 3'd2;
        wr_seq(8, 4, 4, 1, 2'b01, 16'hA000, 1, "R5");
        wr_seq(12, 4, 4, 2, 2'b10, 16'hB000, 1, "R5");
        idle(2);
        bl_code = 3'd3;
        rd_seq(8, 1, 8, 8, 1, -1, 2'b00, "R5");
        idle(4);

        // Read masks at latency 2, both latencies (R6).
        bl_code = 3'd2;
        rd_seq(0, 1, 4, 4, 1, 1, 2'b10, "R6");
        idle(4);
        cl = 3;
        rd_seq(0, 1, 4, 4, 1, 2, 2'b01, "R6");
        idle(4);

        // Gapless back-to-back reads, then release (R7).
        cl = 2; bl_code = 3'd1;
        rd_seq(16, 1, 2, 2, 0, -1, 2'b00, "R7");
        rd_seq(20, 1, 2, 2, 1, -1, 2'b00, "R7");
        idle(4);

        // Read interrupted by a read (R8).
        bl_code = 3'd3;
        rd_seq(0, 1, 2, 2, 0, -1, 2'b00, "R8");
        rd_seq(24, 1, 8, 8, 1, -1, 2'b00, "R8");
        idle(4);
        // Continuous read ended by stop (R8).
        cl = 3; bl_code = 3'd7;
        rd_seq(2, 1, 5, 5, 1, -1, 2'b00, "R8");
        drive(0, 0, 1, 0, 0, 2'b00, 16'h0);
        idle(5);
        // Length 8 read ended by precharge (R8).
        cl = 2; bl_code = 3'd3;
        rd_seq(10, 1, 3, 3, 1, -1, 2'b00, "R8");
        drive(0, 0, 0, 1, 0, 2'b00, 16'h0);
        idle(5);

        // Write cancels pending read words (R9).
        begin
            int k;
            cl = 3; bl_code = 3'd2;
            k = cyc;
            rd_seq(0, 1, 2, 0, 0, -1, 2'b00, "R9");
            push_exp(k + 3, 2'b00, 16'h0, "R9");
            push_exp(k + 4, 2'b00, 16'h0, "R9");
            bl_code = 3'd0;
            wr_seq(30, 1, 1, -1, 2'b00, 16'h5A5A, 0, "R9");
        end
        idle(5);
        cl = 2;
        rd_seq(30, 1, 1, 1, 1, -1, 2'b00, "R9");
        idle(4);

        // Single-word write mode (R10).
        single_wr = 1'b1; bl_code = 3'd2;
        wr_seq(4, 4, 1, -1, 2'b00, 16'hC000, 1, "R10");
        idle(2);
        single_wr = 1'b0;
        rd_seq(4, 1, 4, 4, 1, -1, 2'b00, "R10");
        idle(6);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule